// File: doc/BRIEF.md
# Cartridge-Port Reset and Menu Detector

This block infers the host processor's reset state from signals seen at a cartridge slot that has no reset line. It samples the two bank-select port bits, the active-low program-store strobe and the twelve address lines on its own free-running clock. It reports a reset-active level, a one-cycle pulse when reset ends, and a write window during which the cartridge side may load its SRAM. The window is open because the external bus is idle.

Reset is taken to be active when both bank bits read high and no program fetch is under way, after that condition has held for a debounce count. Reset ends in one of two ways. The processor's first fetch after reset, from address 0x400 with the strobe low, ends it at once. Otherwise, the condition must be absent for the debounce count. A reset held for a parameterised number of cycles, three seconds by default, raises a menu request. The request stays up until it is acknowledged. The block also flags that the post-reset fetch from 0x400 has been seen.

Top module: `cart_reset_detector`

## Requirements
- R1: After `rst_n` is released, `rst_active`, `rst_release`, `menu_req`, `boot_fetch_seen` and `load_window` are all 0.
- R2: Both bank bits high together with `fetch_n` high, held steady, make `rst_active` go high on the DEB_CYCLES+2'th rising edge after the change, and not before.
- R3: A reset condition that lasts fewer than DEB_CYCLES cycles leaves `rst_active` low.
- R4: While `rst_active` is high, a boot fetch (`fetch_n` low with `addr` = 0x400) drives `rst_active` low on the third rising edge after it is applied, bypassing the debounce.
- R5: While `rst_active` is high, a fetch from any other address clears `rst_active` only after the debounce, on the DEB_CYCLES+2'th edge.
- R6: `rst_release` is high for exactly one cycle, in the cycle where `rst_active` first reads low after being high.
- R7: `menu_req` rises HOLD_CYCLES edges after `rst_active` rose, if `rst_active` stayed high. It then stays high, even after reset ends, until a cycle with `menu_ack` high. `menu_req` reads low after that edge.
- R8: A reset shorter than HOLD_CYCLES cycles produces the release pulse and no menu request, and the hold count restarts from zero each time `rst_active` drops.
- R9: `boot_fetch_seen` goes high on the edge where a boot fetch is registered after a rise of `rst_active`. It returns to 0 on the next rise of `rst_active`.
- R10: `load_window` is high only while `rst_active` is high and the synchronised `fetch_n` is high. Any fetch lowers it on the third edge after the fetch is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Active-low reset of the detector itself |
| bank_bits | input | 2 | Bank-select port bits from the cartridge slot (asynchronous) |
| fetch_n | input | 1 | Program-store strobe, active low (asynchronous) |
| addr | input | 12 | Cartridge address lines (asynchronous) |
| menu_ack | input | 1 | Clears a pending menu request (clock-synchronous) |
| rst_active | output | 1 | Host is inferred to be in reset |
| rst_release | output | 1 | One-cycle pulse when reset ends |
| menu_req | output | 1 | Sticky request to enter the menu |
| boot_fetch_seen | output | 1 | The post-reset fetch from 0x400 has occurred |
| load_window | output | 1 | Bus is idle in reset, so SRAM may be written |

## Verification
Every slot input passes through two synchroniser flops and then a register. A boot fetch or any fetch therefore shows on `rst_active` or `load_window` on the third edge after it is applied. A debounced change takes DEB_CYCLES+2 edges. `menu_req` follows HOLD_CYCLES edges after `rst_active` rose, and an acknowledge takes effect on the next edge. The bench drives inputs on falling edges and counts rising edges from there. For each latency it samples one edge early, expecting the old value, and then exactly on the due edge, expecting the new one. Outputs are read one time step after the edge.

// File: rtl/crd_pkg.sv
package crd_pkg;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] BOOT_ADDR = 12'h400;

    function automatic logic is_boot_fetch(input logic strobe_n, input logic [ADDR_W-1:0] a);
        return !strobe_n && (a == BOOT_ADDR);
    endfunction
endpackage

// File: rtl/crd_sync.sv
module crd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/crd_hold_timer.sv
module crd_hold_timer #(
    parameter int HOLD_CYCLES = 150_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic hit
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = en && (cnt_q == CW'(HOLD_CYCLES - 1));
        cnt_d = cnt_q;
        if (!en)                            cnt_d = '0;
        else if (cnt_q != CW'(HOLD_CYCLES)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));
endmodule

// File: rtl/cart_reset_detector.sv
module cart_reset_detector #(
    parameter int DEB_CYCLES  = 50_000,
    parameter int HOLD_CYCLES = 150_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bank_bits,
    input  logic        fetch_n,
    input  logic [11:0] addr,
    input  logic        menu_ack,
    output logic        rst_active,
    output logic        rst_release,
    output logic        menu_req,
    output logic        boot_fetch_seen,
    output logic        load_window
);
    import crd_pkg::*;

    localparam int SW = 2 + 1 + ADDR_W;
    localparam int DW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic          active;
        logic          release_p;
        logic          menu;
        logic          armed;
        logic          seen;
        logic          window;
        logic [DW-1:0] deb_cnt;
    } det_state_t;

    det_state_t s_d, s_q;
    logic [SW-1:0] raw, synced;
    logic [1:0]    s_bank;
    logic          s_fetch_n;
    logic [ADDR_W-1:0] s_addr;
    logic          cond, boot, hold_hit;

    assign raw = {addr, fetch_n, bank_bits};

    crd_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    crd_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .en(s_q.active), .hit(hold_hit)
    );

    assign s_bank    = synced[1:0];
    assign s_fetch_n = synced[2];
    assign s_addr    = synced[SW-1:3];
    assign cond      = (&s_bank) && s_fetch_n;
    assign boot      = is_boot_fetch(s_fetch_n, s_addr);

    always_comb begin
        s_d = s_q;
        if (cond != s_q.active) begin
            if (s_q.deb_cnt == DW'(DEB_CYCLES - 1)) begin
                s_d.active  = cond;
                s_d.deb_cnt = '0;
            end else begin
                s_d.deb_cnt = s_q.deb_cnt + 1'b1;
            end
        end else begin
            s_d.deb_cnt = '0;
        end
        if (boot && s_q.active) begin
            s_d.active  = 1'b0;
            s_d.deb_cnt = '0;
        end
        if (s_d.active && !s_q.active) begin
            s_d.armed = 1'b1;
            s_d.seen  = 1'b0;
        end else if (boot && s_q.armed) begin
            s_d.armed = 1'b0;
            s_d.seen  = 1'b1;
        end
        s_d.release_p = s_q.active && !s_d.active;
        s_d.window    = s_d.active && s_fetch_n;
        s_d.menu      = hold_hit || (s_q.menu && !menu_ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rst_active      = s_q.active;
    assign rst_release     = s_q.release_p;
    assign menu_req        = s_q.menu;
    assign boot_fetch_seen = s_q.seen;
    assign load_window     = s_q.window;

    // R4
    boot_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && boot) |=> !rst_active);
    // R6
    release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_release |=> !rst_release);
    // R6
    release_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active) |-> rst_release);
    // R7
    menu_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (menu_req && !menu_ack) |=> menu_req);
    // R10
    window_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_window |-> rst_active);
endmodule

// File: tb/tb_cart_reset_detector.sv
module tb_cart_reset_detector;
    localparam int DEB  = 4;
    localparam int HOLD = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bank_bits = 2'b00;
    logic        fetch_n = 1'b1;
    logic [11:0] addr = 12'h000;
    logic        menu_ack = 1'b0;
    logic        rst_active, rst_release, menu_req, boot_fetch_seen, load_window;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cart_reset_detector #(.DEB_CYCLES(DEB), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .bank_bits(bank_bits), .fetch_n(fetch_n),
        .addr(addr), .menu_ack(menu_ack), .rst_active(rst_active),
        .rst_release(rst_release), .menu_req(menu_req),
        .boot_fetch_seen(boot_fetch_seen), .load_window(load_window)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [1:0] b, input logic f, input logic [11:0] a);
        @(negedge clk);
        bank_bits = b; fetch_n = f; addr = a;
    endtask

    task automatic t_reset_state();
        edges(3);
        rst_n = 1'b1;
        edges(2);
        check("R1", "rst_active", rst_active, 1'b0);
        check("R1", "rst_release", rst_release, 1'b0);
        check("R1", "menu_req", menu_req, 1'b0);
        check("R1", "boot_fetch_seen", boot_fetch_seen, 1'b0);
        check("R1", "load_window", load_window, 1'b0);
    endtask

    task automatic t_short_reset_boot();
        drive(2'b11, 1'b1, 12'h000);
        edges(DEB + 1);
        check("R2", "active early", rst_active, 1'b0);
        edges(1);
        check("R2", "active due", rst_active, 1'b1);
        check("R10", "window open", load_window, 1'b1);
        edges(5);
        drive(2'b11, 1'b0, 12'h400);
        edges(2);
        check("R4", "active before boot seen", rst_active, 1'b1);
        edges(1);
        check("R4", "active after boot", rst_active, 1'b0);
        check("R6", "release pulse", rst_release, 1'b1);
        check("R9", "seen set", boot_fetch_seen, 1'b1);
        edges(1);
        check("R6", "release one cycle", rst_release, 1'b0);
        drive(2'b00, 1'b1, 12'h000);
        edges(HOLD + 5);
        check("R8", "no menu after short reset", menu_req, 1'b0);
    endtask

    task automatic t_glitch();
        drive(2'b11, 1'b1, 12'h000);
        repeat (DEB - 1) @(negedge clk);
        bank_bits = 2'b00;
        edges(10);
        check("R3", "glitch ignored", rst_active, 1'b0);
    endtask

    task automatic t_long_reset();
        drive(2'b11, 1'b1, 12'h000);
        edges(DEB + 2);
        check("R2", "active again", rst_active, 1'b1);
        check("R9", "seen cleared on rise", boot_fetch_seen, 1'b0);
        edges(HOLD - 1);
        check("R7", "menu early", menu_req, 1'b0);
        edges(1);
        check("R7", "menu due", menu_req, 1'b1);
        drive(2'b11, 1'b0, 12'h123);
        edges(2);
        check("R10", "window before fetch seen", load_window, 1'b1);
        edges(1);
        check("R10", "window closed by fetch", load_window, 1'b0);
        check("R5", "active held in debounce", rst_active, 1'b1);
        edges(DEB - 2);
        check("R5", "active before debounce end", rst_active, 1'b1);
        edges(1);
        check("R5", "active after debounce", rst_active, 1'b0);
        check("R6", "release on debounced fall", rst_release, 1'b1);
        check("R9", "other address not boot", boot_fetch_seen, 1'b0);
        edges(3);
        check("R7", "menu sticky after reset", menu_req, 1'b1);
        drive(2'b00, 1'b0, 12'h400);
        edges(3);
        check("R9", "boot after debounced release", boot_fetch_seen, 1'b1);
        @(negedge clk);
        menu_ack = 1'b1;
        edges(1);
        check("R7", "menu cleared by ack", menu_req, 1'b0);
        @(negedge clk);
        menu_ack = 1'b0;
        edges(2);
        check("R7", "menu stays clear", menu_req, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_short_reset_boot();
        t_glitch();
        t_long_reset();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule